// File: doc/BRIEF.md
# Burst QPSK Baseband I/Q Generator

This block turns a serial bit stream into shaped digital in-phase and quadrature baseband samples for a burst QPSK transmitter. A free-running divider derives the serial data clock from the master clock. While the transmit enable is high, one input bit is taken per data-clock period. The bits are split by their position in the burst: the first goes to the in-phase path, the next to quadrature, and so on. Each completed pair forms one symbol.

Each path maps its bit to a signed impulse and inserts zeros to reach eight samples per symbol. The result passes through a fixed 33-tap root-raised-cosine interpolator with a roll-off of 0.5. The filtered value is rounded and saturated to a signed 9-bit sample, and each sample comes with a one-cycle valid strobe for an external converter.

When the enable drops, any unpaired bit is completed and the filters are run out with zero input. After that the outputs are held at zero. Raising the enable again starts a clean burst.

Top module: `bqm_iq_gen`

## Requirements
- R1: `bit_clk` has a period of exactly 100 master clocks. After reset it is high for the first 50 cycles of each period and low for the other 50.
- R2: `tx_data` is sampled once per data-clock period, on the master-clock edge that ends the first cycle in which `bit_clk` is high. It is sampled only while `tx_en` is high at that edge.
- R3: The first bit sampled after `tx_en` rises goes to the I path, and the bits that follow alternate Q, I, Q and so on. A symbol enters both filters at the edge where its Q bit is sampled.
- R4: Bit value 0 enters the filter as a positive impulse and bit value 1 as a negative impulse. Each symbol impulse is followed by seven zero samples, so there are 8 filter samples per symbol. A single isolated positive symbol gives a peak of +227, and a single negative symbol gives -227.
- R5: Let the phase p count master clocks since `bit_clk` last rose, with p = 0 in the first high cycle. While a burst or its flush is in progress, the filters advance on the edges ending phases p = 0, 25, 50 and 75. `i_valid` and `q_valid` are high for exactly one cycle, at p = 2, 27, 52 and 77. The sample outputs change only in those cycles.
- R6: Each sample is the sum of its taps weighted by the impulses in the line. The taps are symmetric, listed from the centre outward: 3637, 3502, 3118, 2541, 1852, 1143, 502, -5, -340, -497, -502, -398, -240, -78, 50, 122, 136. The sum is rounded by adding 8 and floor-dividing by 16, then saturated to the range -256 to 255.
- R7: A rising edge of `tx_en` clears both filter delay lines and restarts the I/Q alternation. This also holds when the enable falls and rises again between two bit samples.
- R8: If `tx_en` is low at a bit-sampling edge while an I bit is still waiting for its pair, the symbol is completed with a Q bit of value 0, which is a positive impulse.
- R9: When `tx_en` is found low at a bit-sampling edge, the filters run for 33 further sample advances with zero input. After that, and at all times outside a burst, both samples read 0 and both valid strobes stay low.
- R10: A rising edge of `tx_en` during the flush abandons the flush and starts a new burst from cleared filters.
- R11: After a synchronous reset, `bit_clk` is high, both samples are 0 and both valid strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Burst enable |
| tx_data | input | 1 | Serial transmit bit |
| bit_clk | output | 1 | Serial data clock, master clock divided by 100 |
| i_sample | output | 9 | Shaped in-phase sample, two's complement |
| i_valid | output | 1 | One-cycle strobe for `i_sample` |
| q_sample | output | 9 | Shaped quadrature sample, two's complement |
| q_valid | output | 1 | One-cycle strobe for `q_sample` |

## Verification
The hardest states to reach from the ports are the ones that depend on where the enable edges fall relative to the divider. These are an odd bit count at burst end, a re-enable while the flush is still running, and a short enable dropout that contains no sampling edge. The stimulus lines every burst up with a known divider phase and then holds the enable for chosen lengths (700 cycles always gives seven bits). The dropout is placed so that it falls between two sampling edges. A data pattern of alternating I symbols pushes the outer taps to add in phase, which drives the rounding past the 9-bit limit and exercises saturation.

// File: rtl/bqm_pkg.sv
package bqm_pkg;

    localparam int SAMP_W     = 9;
    localparam int ACC_W      = 20;
    localparam int COEF_W     = 16;
    localparam int FRAC       = 4;
    localparam int ROUND_HALF = 1 << (FRAC - 1);
    localparam int SAMP_MAX   = (1 << (SAMP_W - 1)) - 1;
    localparam int SAMP_MIN   = -(1 << (SAMP_W - 1));

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } burst_st_t;

    // One filter input sample: zero, +full scale or -full scale
    typedef struct packed {
        logic nz;
        logic neg;
    } lvl_t;

    function automatic lvl_t bit_to_lvl(input logic b);
        lvl_t l;
        l.nz  = 1'b1;
        l.neg = b;
        return l;
    endfunction

    // Root-raised-cosine taps, roll-off 0.5, 8 samples/symbol, scaled by 3200
    function automatic logic signed [COEF_W-1:0] rrc_tap(input int k, input int taps);
        int d;
        d = k - taps / 2;
        if (d < 0) d = -d;
        case (d)
            0:  return 16'sd3637;
            1:  return 16'sd3502;
            2:  return 16'sd3118;
            3:  return 16'sd2541;
            4:  return 16'sd1852;
            5:  return 16'sd1143;
            6:  return 16'sd502;
            7:  return -16'sd5;
            8:  return -16'sd340;
            9:  return -16'sd497;
            10: return -16'sd502;
            11: return -16'sd398;
            12: return -16'sd240;
            13: return -16'sd78;
            14: return 16'sd50;
            15: return 16'sd122;
            16: return 16'sd136;
            default: return 16'sd0;
        endcase
    endfunction

    function automatic logic signed [SAMP_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] r;
        r = (a + $signed(ACC_W'(ROUND_HALF))) >>> FRAC;
        if (r > $signed(ACC_W'(SAMP_MAX)))
            return SAMP_W'(SAMP_MAX);
        else if (r < $signed(ACC_W'(SAMP_MIN)))
            return SAMP_W'(SAMP_MIN);
        else
            return SAMP_W'(r);
    endfunction

endpackage

// File: rtl/bqm_timebase.sv
module bqm_timebase #(
    parameter int DIV      = 100,
    parameter int STEP_LEN = 25
) (
    input  logic clk,
    input  logic rst,
    output logic bit_clk,
    output logic tick,
    output logic step
);
    localparam int CW = $clog2(DIV);
    localparam int SW = $clog2(STEP_LEN);

    logic [CW-1:0] cnt;
    logic [SW-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sub <= '0;
        end else begin
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
            sub <= (sub == SW'(STEP_LEN - 1)) ? '0 : sub + 1'b1;
        end
    end

    assign bit_clk = (cnt < CW'(DIV / 2));
    assign tick    = (cnt == '0);
    assign step    = (sub == '0);

    // R1: bit clock rises only after a full divider period
    assert_dclk_period_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(bit_clk) |-> $past(cnt) == CW'(DIV - 1));

    // R5: every bit-sampling edge is also a filter advance edge
    assert_tick_on_step_R5: assert property (@(posedge clk) disable iff (rst)
        tick |-> step);

endmodule

// File: rtl/bqm_burst_ctrl.sv
module bqm_burst_ctrl
    import bqm_pkg::*;
#(
    parameter int TAPS = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_data,
    input  logic tick,
    input  logic step,
    output logic clr,
    output logic shift,
    output lvl_t lvl_i,
    output lvl_t lvl_q,
    output logic active
);
    localparam int FW = $clog2(TAPS);

    burst_st_t     st, st_n;
    logic          en_q;
    logic          par, par_n;
    logic          ibit, ibit_n;
    logic [FW-1:0] fcnt, fcnt_n;
    logic          rise;

    assign rise   = tx_en & ~en_q;
    assign active = (st != ST_IDLE);

    always_comb begin
        st_n   = st;
        par_n  = par;
        ibit_n = ibit;
        fcnt_n = fcnt;
        clr    = 1'b0;
        shift  = 1'b0;
        lvl_i  = '0;
        lvl_q  = '0;
        if (rise) begin
            clr    = 1'b1;
            st_n   = ST_RUN;
            fcnt_n = '0;
            par_n  = 1'b0;
            if (tick) begin
                ibit_n = tx_data;
                par_n  = 1'b1;
            end
        end else begin
            case (st)
                ST_RUN: begin
                    if (step) begin
                        shift = 1'b1;
                        if (tick) begin
                            if (tx_en) begin
                                if (!par) begin
                                    ibit_n = tx_data;
                                    par_n  = 1'b1;
                                end else begin
                                    lvl_i = bit_to_lvl(ibit);
                                    lvl_q = bit_to_lvl(tx_data);
                                    par_n = 1'b0;
                                end
                            end else begin
                                if (par) begin
                                    lvl_i = bit_to_lvl(ibit);
                                    lvl_q = bit_to_lvl(1'b0);
                                    par_n = 1'b0;
                                end
                                st_n   = ST_FLUSH;
                                fcnt_n = '0;
                            end
                        end
                    end
                end
                ST_FLUSH: begin
                    if (step) begin
                        shift = 1'b1;
                        if (fcnt == FW'(TAPS - 1))
                            st_n = ST_IDLE;
                        else
                            fcnt_n = fcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            en_q <= 1'b0;
            par  <= 1'b0;
            ibit <= 1'b0;
            fcnt <= '0;
        end else begin
            st   <= st_n;
            en_q <= tx_en;
            par  <= par_n;
            ibit <= ibit_n;
            fcnt <= fcnt_n;
        end
    end

    // R7: an enable edge away from a sampling edge leaves no bit pending
    assert_rise_restarts_pair_R7: assert property (@(posedge clk) disable iff (rst)
        (rise && !tick) |=> !par);

    // R9: the burst ends only through the flush
    assert_idle_via_flush_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st) != ST_IDLE) |-> $past(st) == ST_FLUSH);

endmodule

// File: rtl/bqm_rrc_fir.sv
module bqm_rrc_fir
    import bqm_pkg::*;
#(
    parameter int TAPS = 33
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     shift,
    input  lvl_t                     din,
    input  logic                     upd,
    input  logic                     gate,
    output logic signed [SAMP_W-1:0] dout,
    output logic                     vld
);
    lvl_t [TAPS-1:0]         line;
    logic signed [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr)
            line <= '0;
        else if (shift)
            line <= {line[TAPS-2:0], din};
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            if (line[k].nz) begin
                if (line[k].neg)
                    acc = acc - ACC_W'(rrc_tap(k, TAPS));
                else
                    acc = acc + ACC_W'(rrc_tap(k, TAPS));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            vld  <= 1'b0;
        end else if (!gate) begin
            dout <= '0;
            vld  <= 1'b0;
        end else if (upd) begin
            dout <= round_sat(acc);
            vld  <= 1'b1;
        end else begin
            vld  <= 1'b0;
        end
    end

    // R7: a clear leaves an empty delay line
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0));

    // R9: outside a burst the output is forced to zero
    assert_gate_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !gate |=> (dout == '0 && !vld));

endmodule

// File: rtl/bqm_iq_gen.sv
module bqm_iq_gen
    import bqm_pkg::*;
#(
    parameter int DIV           = 100,
    parameter int SPS           = 8,
    parameter int BITS_PER_SYM  = 2,
    parameter int TAPS          = 33
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tx_en,
    input  logic                     tx_data,
    output logic                     bit_clk,
    output logic signed [SAMP_W-1:0] i_sample,
    output logic                     i_valid,
    output logic signed [SAMP_W-1:0] q_sample,
    output logic                     q_valid
);
    localparam int STEP_LEN = (DIV * BITS_PER_SYM) / SPS;
    localparam int NCH      = 2;

    logic tick, step, step_d;
    logic clr, shift, active;
    lvl_t lvl_i, lvl_q;
    lvl_t [NCH-1:0]                     ch_in;
    logic [NCH-1:0][SAMP_W-1:0]         ch_out;
    logic [NCH-1:0]                     ch_vld;

    bqm_timebase #(.DIV(DIV), .STEP_LEN(STEP_LEN)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .bit_clk (bit_clk),
        .tick    (tick),
        .step    (step)
    );

    bqm_burst_ctrl #(.TAPS(TAPS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .tx_data (tx_data),
        .tick    (tick),
        .step    (step),
        .clr     (clr),
        .shift   (shift),
        .lvl_i   (lvl_i),
        .lvl_q   (lvl_q),
        .active  (active)
    );

    always_ff @(posedge clk) begin
        if (rst) step_d <= 1'b0;
        else     step_d <= step;
    end

    assign ch_in[0] = lvl_i;
    assign ch_in[1] = lvl_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [SAMP_W-1:0] y;
        bqm_rrc_fir #(.TAPS(TAPS)) u_fir (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .shift (shift),
            .din   (ch_in[c]),
            .upd   (step_d),
            .gate  (active),
            .dout  (y),
            .vld   (ch_vld[c])
        );
        assign ch_out[c] = y;
    end

    assign i_sample = $signed(ch_out[0]);
    assign q_sample = $signed(ch_out[1]);
    assign i_valid  = ch_vld[0];
    assign q_valid  = ch_vld[1];

    // R5: a valid strobe lasts a single cycle
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> !i_valid);

    // R5: both paths strobe together
    assert_valid_paired_R5: assert property (@(posedge clk) disable iff (rst)
        i_valid == q_valid);

endmodule

// File: tb/sim_bqm_iq_gen.sv
module sim_bqm_iq_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0;
    logic tx_data = 1'b0;
    logic bit_clk;
    logic signed [8:0] i_sample, q_sample;
    logic i_valid, q_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bqm_iq_gen u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_data(tx_data),
        .bit_clk(bit_clk), .i_sample(i_sample), .i_valid(i_valid),
        .q_sample(q_sample), .q_valid(q_valid)
    );

    // taps from the centre outward (R6)
    int H[17] = '{3637, 3502, 3118, 2541, 1852, 1143, 502, -5, -340,
                  -497, -502, -398, -240, -78, 50, 122, 136};

    // behavioural reference state
    int m_div, m_st, m_par, m_ibit, m_fcnt, m_enq, m_stepd;
    int m_oi, m_oq, m_vld, m_dclk;
    int linI[$], linQ[$];
    string tag = "R11";
    int cyc = 0, bcnt = 0, mode = 0;
    int mx_i, mn_i, mx_q, mn_q;
    int last_vld = -1000, last_rise = -1, period = 0;
    logic prev_clk_o = 1'b1;

    function automatic int fir_out(ref int ln[$]);
        int acc = 0;
        int r;
        foreach (ln[k]) begin
            int d = (k > 16) ? k - 16 : 16 - k;
            acc += ln[k] * H[d];
        end
        r = (acc + 8) >>> 4;
        if (r > 255) r = 255;
        if (r < -256) r = -256;
        return r;
    endfunction

    function automatic int lv(int b);
        return (b != 0) ? -1 : 1;
    endfunction

    task automatic clear_lines();
        linI.delete(); linQ.delete();
        for (int k = 0; k < 33; k++) begin linI.push_back(0); linQ.push_back(0); end
    endtask

    task automatic push(int a, int b);
        linI.push_front(a); void'(linI.pop_back());
        linQ.push_front(b); void'(linQ.pop_back());
    endtask

    task automatic model_reset();
        m_div = 0; m_st = 0; m_par = 0; m_ibit = 0; m_fcnt = 0; m_enq = 0;
        m_stepd = 0; m_oi = 0; m_oq = 0; m_vld = 0; m_dclk = 1;
        clear_lines();
    endtask

    task automatic model_next(int en, int d);
        int tick = (m_div == 0);
        int step = (m_div % 25 == 0);
        int rise = en && !m_enq;
        if (m_st == 0) begin m_oi = 0; m_oq = 0; m_vld = 0; end
        else if (m_stepd != 0) begin m_oi = fir_out(linI); m_oq = fir_out(linQ); m_vld = 1; end
        else m_vld = 0;
        if (rise) begin
            clear_lines(); m_st = 1; m_fcnt = 0; m_par = 0;
            if (tick) begin m_ibit = d; m_par = 1; end
        end else if (m_st == 1 && step) begin
            int a = 0, b = 0;
            if (tick) begin
                if (en) begin
                    if (m_par == 0) begin m_ibit = d; m_par = 1; end
                    else begin a = lv(m_ibit); b = lv(d); m_par = 0; end
                end else begin
                    if (m_par == 1) begin a = lv(m_ibit); b = lv(0); m_par = 0; end
                    m_st = 2; m_fcnt = 0;
                end
            end
            push(a, b);
        end else if (m_st == 2 && step) begin
            push(0, 0);
            if (m_fcnt == 32) m_st = 0; else m_fcnt++;
        end
        m_stepd = step;
        m_enq = en;
        m_div = (m_div == 99) ? 0 : m_div + 1;
        m_dclk = (m_div < 50);
    endtask

    task automatic compare();
        int ai = int'(i_sample);
        int aq = int'(q_sample);
        checks++;
        if (bit_clk !== m_dclk[0] || i_valid !== m_vld[0] || q_valid !== m_vld[0] ||
            ai != m_oi || aq != m_oq) begin
            fails++;
            $display("FAIL %s cycle %0d: clk_o=%0b/%0d vld=%0b%0b/%0d i=%0d/%0d q=%0d/%0d (actual/expected)",
                     tag, cyc, bit_clk, m_dclk, i_valid, q_valid, m_vld, ai, m_oi, aq, m_oq);
        end
        if (ai > mx_i) mx_i = ai;
        if (ai < mn_i) mn_i = ai;
        if (aq > mx_q) mx_q = aq;
        if (aq < mn_q) mn_q = aq;
        // R5: strobes inside a burst come 25 cycles apart
        if (i_valid) begin
            if (cyc - last_vld <= 25) begin
                checks++;
                if (cyc - last_vld != 25) begin
                    fails++;
                    $display("FAIL R5 valid spacing: actual %0d expected 25", cyc - last_vld);
                end
            end
            last_vld = cyc;
        end
        // R1: period measurement
        if (bit_clk && !prev_clk_o) begin
            if (last_rise >= 0 && period == 0) period = cyc - last_rise;
            last_rise = cyc;
        end
        prev_clk_o = bit_clk;
    endtask

    task automatic drive(int en, int d);
        tx_en = en[0]; tx_data = d[0];
        model_next(en, d);
        @(posedge clk); #1;
        cyc++;
        compare();
        @(negedge clk);
    endtask

    function automatic int data_bit();
        case (mode)
            0: return 0;
            1: return 1;
            2: return int'($urandom_range(0, 1));
            3: return (bcnt / 100) % 2;
            default: return (bcnt / 200) % 2;
        endcase
    endfunction

    task automatic seg(int en, int n);
        for (int k = 0; k < n; k++) begin
            drive(en, data_bit());
            bcnt++;
        end
    endtask

    task automatic align();
        while (m_div != 50) drive(0, 0);
        bcnt = 0;
        mx_i = -1000; mn_i = 1000; mx_q = -1000; mn_q = 1000;
    endtask

    task automatic to_idle();
        int g = 0;
        drive(0, 0);
        while (m_st != 0 && g < 5000) begin drive(0, 0); g++; end
        repeat (5) drive(0, 0);
    endtask

    task automatic chk(bit ok, string what, int act, int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp_v);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk(bit_clk === 1'b1, "R11 bit_clk after reset", int'(bit_clk), 1);
        chk(i_sample === 9'sd0 && q_sample === 9'sd0, "R11 samples after reset", int'(i_sample), 0);
        chk(i_valid === 1'b0 && q_valid === 1'b0, "R11 strobes after reset", int'(i_valid), 0);

        // R9 and R1: idle with toggling data, outputs held at zero
        tag = "R9 idle";
        for (int k = 0; k < 300; k++) drive(0, k % 2);
        chk(period == 100, "R1 data clock period", period, 100);

        // R3 R4: one symbol of two zero bits gives a +227 peak on I
        tag = "R4 single positive symbol"; mode = 0;
        align(); seg(1, 200); to_idle();
        chk(mx_i == 227, "R4 positive peak", mx_i, 227);

        tag = "R4 single negative symbol"; mode = 1;
        align(); seg(1, 200); to_idle();
        chk(mn_i == -227, "R4 negative peak", mn_i, -227);

        // R3: bits alternate 0,1 so I carries only + and Q only -
        tag = "R3 demux order"; mode = 3;
        align(); seg(1, 1200); to_idle();
        chk(mx_i >= 200, "R3 I positive", mx_i, 200);
        chk(mn_i > -200, "R3 I never strongly negative", mn_i, -199);
        chk(mn_q <= -200, "R3 Q negative", mn_q, -200);
        chk(mx_q < 200, "R3 Q never strongly positive", mx_q, 199);

        // R2 R6: random data
        tag = "R2 R6 random burst"; mode = 2;
        align(); seg(1, 3000); to_idle();

        // R6: alternating I symbols push the sum past the 9-bit range
        tag = "R6 saturation"; mode = 4;
        align(); seg(1, 2000); to_idle();
        chk(mx_i == 255 || mn_i == -256, "R6 saturation reached", mx_i, 255);

        // R8: seven bits of 1, the last Q completes as a 0 bit
        tag = "R8 odd burst"; mode = 1;
        align(); seg(1, 700); to_idle();
        chk(mx_q >= 200, "R8 padded Q bit positive", mx_q, 200);

        // R10: re-enable during flush
        tag = "R10 restart in flush"; mode = 2;
        align(); seg(1, 400); seg(0, 300); seg(1, 400); to_idle();

        // R7: dropout between two sampling edges
        tag = "R7 dropout"; mode = 2;
        align(); seg(1, 305); seg(0, 10); seg(1, 400); to_idle();

        // R9: back to idle
        tag = "R9 after bursts";
        repeat (200) drive(0, 1);
        chk(i_sample === 9'sd0 && !i_valid, "R9 idle output", int'(i_sample), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule